// File: doc/BRIEF.md
# Half-Duplex Line Direction Controller

This block steers an external half-duplex line driver around bursts of serial transmission. When the automatic direction mode is on, it raises the request-to-send line (`rts`) a set number of bit times before the transmitter may send its first start bit. It withholds the transmit permit until that lead time has passed. After the last stop bit of the burst, it keeps `rts` high for a set number of bit times before it releases the line. During that trailing window it raises `hold_active`, which an echo-suppression gate can use as its blanking delay.

Both delays come from one 8-bit configuration byte. The upper nibble is the lead (setup) count and the lower nibble is the trailing (hold) count. Each is counted in bit intervals, from 0 to 15. The block counts on the `bit_tick` strobe and not on the system clock, so the delays scale with the baud rate and with the 2x and 4x rate modes. The serial shifter is outside the block. It reports `tx_pending` (data waiting) and `tx_idle` (last stop bit sent), and it waits for `tx_permit` before it starts.

There are four states: IDLE, SETUP, TRANSMIT and HOLD. The transitions are as follows:
- IDLE→SETUP when data is pending.
- SETUP→TRANSMIT on the bit tick that finds the setup count exhausted.
- TRANSMIT→HOLD when nothing is pending and the shifter is idle.
- HOLD→TRANSMIT as soon as new data is pending.
- HOLD→IDLE on the bit tick that finds the hold count exhausted.
- Any state→IDLE while the mode is off.

Top module: `hdx_dir_ctrl`

## Requirements
- R1: After reset, with `auto_en`=1 and no pending data, the outputs are `rts`=0, `tx_permit`=0 and `hold_active`=0 (state IDLE).
- R2: While `auto_en`=0, the outputs are `rts`=0, `tx_permit`=1 and `hold_active`=0 whatever the other inputs do, and the state stays IDLE. After `auto_en` returns to 1 with nothing pending, all three outputs read 0.
- R3: In IDLE with `auto_en`=1, `tx_pending`=1 raises `rts` in the next cycle (IDLE→SETUP) while `tx_permit` stays 0.
- R4: With setup field `delay_cfg[7:4]`=N, `tx_permit` rises after the (N+1)-th `bit_tick` counted from the cycle SETUP is entered. After N ticks it is still 0 (SETUP→TRANSMIT).
- R5: A setup field of 0 grants `tx_permit` on the first `bit_tick` in SETUP.
- R6: In TRANSMIT, `tx_pending`=0 together with `tx_idle`=1 moves to HOLD in the next cycle. In HOLD, `rts`=1, `hold_active`=1 and `tx_permit`=0.
- R7: With hold field `delay_cfg[3:0]`=H, `rts` and `hold_active` fall after the (H+1)-th `bit_tick` in HOLD (HOLD→IDLE). A hold field of 0 releases the line on the first tick.
- R8: `tx_pending`=1 during HOLD returns the block to TRANSMIT in the next cycle, with `rts` kept high and no setup delay.
- R9: TRANSMIT is left only on R6's condition. Bit ticks, and an idle shifter while data is still pending, leave `rts`=1 and `tx_permit`=1.
- R10: Clearing `auto_en` in the middle of a burst gives the disabled outputs at once. Setting it again restarts from IDLE, so pending data goes through a fresh SETUP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| delay_cfg | input | 8 | [7:4] setup bit count, [3:0] hold bit count |
| auto_en | input | 1 | Automatic direction mode enable |
| bit_tick | input | 1 | One-cycle strobe per bit interval |
| tx_pending | input | 1 | Transmit data waiting |
| tx_idle | input | 1 | Shifter idle, last stop bit sent |
| rts | output | 1 | Line driver enable |
| tx_permit | output | 1 | Shifter may start a character |
| hold_active | output | 1 | Trailing hold window, echo blanking |

## Verification
The outputs are decoded from the state register and `auto_en` only. A change in `tx_pending`, `tx_idle` or a `bit_tick` therefore shows on the outputs one clock after the edge that samples it. A change of `auto_en` shows on the outputs in the same cycle. The bench drives every input just after a falling edge and reads the outputs at the next falling edge, which places each sample after the single rising edge that acts on it. Setup and hold windows are measured by counting one-cycle tick pulses. The outputs are checked after N and after N+1 ticks, so an off-by-one in either direction is caught.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
    localparam int FIELD_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_XMIT  = 2'd2,
        ST_HOLD  = 2'd3
    } hdx_state_e;

    typedef struct packed {
        logic rts;
        logic permit;
        logic hold;
    } hdx_out_t;
endpackage

// File: rtl/hdx_delay_counter.sv
module hdx_delay_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         is_zero
);
    logic [W-1:0] cnt;

    // Load wins over a simultaneous tick; the count rests at zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (tick && (cnt != '0))
            cnt <= cnt - 1'b1;
    end

    assign is_zero = (cnt == '0);
endmodule

// File: rtl/hdx_out_decode.sv
module hdx_out_decode
    import hdx_pkg::*;
(
    input  hdx_state_e state,
    input  logic       auto_en,
    output hdx_out_t   outs
);
    always_comb begin
        outs = '0;
        if (!auto_en) begin
            outs.permit = 1'b1;
        end else begin
            unique case (state)
                ST_IDLE:  outs = '{rts: 1'b0, permit: 1'b0, hold: 1'b0};
                ST_SETUP: outs = '{rts: 1'b1, permit: 1'b0, hold: 1'b0};
                ST_XMIT:  outs = '{rts: 1'b1, permit: 1'b1, hold: 1'b0};
                ST_HOLD:  outs = '{rts: 1'b1, permit: 1'b0, hold: 1'b1};
                default:  outs = '0;
            endcase
        end
    end
endmodule

// File: rtl/hdx_dir_ctrl.sv
module hdx_dir_ctrl
    import hdx_pkg::*;
#(
    parameter int FW = hdx_pkg::FIELD_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2*FW-1:0] delay_cfg,
    input  logic            auto_en,
    input  logic            bit_tick,
    input  logic            tx_pending,
    input  logic            tx_idle,
    output logic            rts,
    output logic            tx_permit,
    output logic            hold_active
);
    localparam int CFG_W = 2 * FW;

    hdx_state_e state, state_nxt;
    logic       cnt_load;
    logic [FW-1:0] cnt_val;
    logic       cnt_zero;
    hdx_out_t   outs;

    wire [FW-1:0] setup_f = delay_cfg[CFG_W-1:FW];
    wire [FW-1:0] hold_f  = delay_cfg[FW-1:0];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    // Transition logic and counter loading
    always_comb begin
        state_nxt = state;
        cnt_load  = 1'b0;
        cnt_val   = hold_f;
        if (!auto_en) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: if (tx_pending) begin
                    state_nxt = ST_SETUP;
                    cnt_load  = 1'b1;
                    cnt_val   = setup_f;
                end
                ST_SETUP: if (bit_tick && cnt_zero)
                    state_nxt = ST_XMIT;
                ST_XMIT: if (!tx_pending && tx_idle) begin
                    state_nxt = ST_HOLD;
                    cnt_load  = 1'b1;
                    cnt_val   = hold_f;
                end
                ST_HOLD: begin
                    if (tx_pending)
                        state_nxt = ST_XMIT;
                    else if (bit_tick && cnt_zero)
                        state_nxt = ST_IDLE;
                end
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    hdx_delay_counter #(.W(FW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .tick     (bit_tick),
        .is_zero  (cnt_zero)
    );

    hdx_out_decode u_dec (
        .state   (state),
        .auto_en (auto_en),
        .outs    (outs)
    );

    assign rts         = outs.rts;
    assign tx_permit   = outs.permit;
    assign hold_active = outs.hold;
endmodule

// File: rtl/hdx_dir_ctrl_chk.sv
module hdx_dir_ctrl_chk #(
    parameter int FW = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [2*FW-1:0] delay_cfg,
    input logic            auto_en,
    input logic            bit_tick,
    input logic            tx_pending,
    input logic            tx_idle,
    input logic            rts,
    input logic            tx_permit,
    input logic            hold_active
);
    p_disabled_outputs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |-> (!rts && tx_permit && !hold_active));

    p_rise_without_permit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && $rose(rts)) |-> !tx_permit);

    p_permit_needs_rts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && tx_permit) |-> rts);

    p_permit_on_tick_or_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && $past(auto_en) && $rose(tx_permit)) |-> ($past(bit_tick) || $past(hold_active)));

    p_hold_drives_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_active |-> (rts && !tx_permit));

    p_hold_exit_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && $past(auto_en) && $fell(hold_active)) |-> ($past(bit_tick) || $past(tx_pending)));

    p_xmit_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && tx_permit && tx_pending) |=> (!auto_en || tx_permit));
endmodule

bind hdx_dir_ctrl hdx_dir_ctrl_chk #(.FW(FW)) u_chk (.*);

// File: tb/tb_hdx_dir_ctrl.sv
module tb_hdx_dir_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] delay_cfg = 8'h00;
    logic       auto_en = 1'b1;
    logic       bit_tick = 1'b0;
    logic       tx_pending = 1'b0;
    logic       tx_idle = 1'b1;
    logic       rts, tx_permit, hold_active;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hdx_dir_ctrl dut (
        .clk(clk), .rst_n(rst_n), .delay_cfg(delay_cfg), .auto_en(auto_en),
        .bit_tick(bit_tick), .tx_pending(tx_pending), .tx_idle(tx_idle),
        .rts(rts), .tx_permit(tx_permit), .hold_active(hold_active)
    );

    // exp packs {rts, tx_permit, hold_active}
    task automatic chk(input string req, input logic [2:0] exp);
        logic [2:0] act;
        act = {rts, tx_permit, hold_active};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: {rts,permit,hold} actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic tick();
        bit_tick = 1'b1;
        step();
        bit_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        auto_en = 1'b1;
        tx_pending = 1'b0;
        tx_idle = 1'b1;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 reset idle", 3'b000);
    endtask

    task automatic t_disabled();
        auto_en = 1'b0;
        tx_pending = 1'b1;
        tx_idle = 1'b0;
        step();
        chk("R2 disabled outputs", 3'b010);
        ticks(4);
        chk("R2 disabled after ticks", 3'b010);
        tx_pending = 1'b0;
        tx_idle = 1'b1;
        step();
        auto_en = 1'b1;
        step();
        chk("R2 state stayed idle", 3'b000);
    endtask

    // Enters SETUP with field n and walks to TRANSMIT.
    task automatic t_setup(input int n, input int h);
        delay_cfg = {n[3:0], h[3:0]};
        tx_pending = 1'b1;
        tx_idle = 1'b0;
        step();
        chk("R3 rts raised, no permit", 3'b100);
        ticks(n);
        chk(n == 0 ? "R5 setup zero before tick" : "R4 permit held after N ticks", 3'b100);
        tick();
        chk(n == 0 ? "R5 setup zero permit on first tick" : "R4 permit after N+1 ticks", 3'b110);
    endtask

    task automatic t_xmit_steady();
        ticks(3);
        chk("R9 ticks in transmit", 3'b110);
        tx_idle = 1'b1;
        step();
        chk("R9 idle shifter with pending data", 3'b110);
        tx_pending = 1'b0;
        tx_idle = 1'b0;
        step();
        chk("R9 busy shifter keeps transmit", 3'b110);
    endtask

    task automatic t_hold(input int h);
        tx_pending = 1'b0;
        tx_idle = 1'b1;
        step();
        chk("R6 enter hold", 3'b101);
        ticks(h);
        chk("R7 hold after H ticks", 3'b101);
        tick();
        chk("R7 released after H+1 ticks", 3'b000);
        ticks(2);
        chk("R7 stays idle", 3'b000);
    endtask

    task automatic t_reentry();
        t_setup(1, 5);
        tx_pending = 1'b0;
        tx_idle = 1'b1;
        step();
        chk("R6 hold before reentry", 3'b101);
        tick();
        tx_pending = 1'b1;
        tx_idle = 1'b0;
        step();
        chk("R8 back to transmit without setup", 3'b110);
        t_hold(5);
    endtask

    task automatic t_disable_mid();
        t_setup(2, 1);
        auto_en = 1'b0;
        #1;
        chk("R10 disabled outputs at once", 3'b010);
        step();
        tx_pending = 1'b0;
        auto_en = 1'b1;
        step();
        chk("R10 restart from idle", 3'b000);
        tx_pending = 1'b1;
        step();
        chk("R10 fresh setup", 3'b100);
        tick();
        chk("R10 setup not skipped", 3'b100);
        tx_pending = 1'b0;
        tx_idle = 1'b1;
        ticks(2);
        tx_pending = 1'b0;
        t_hold(1);
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_setup(3, 2);
        t_xmit_steady();
        t_hold(2);
        t_setup(0, 0);
        t_hold(0);
        t_setup(15, 15);
        t_hold(15);
        t_reentry();
        t_disable_mid();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule